// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt lines, merges each one with a request bit that software can set, and gates the result with a per-source enable. Each enabled source is sent either to a normal interrupt output or to a fast interrupt output, as chosen by a per-source routing bit. Software sees the block as a small register window on a simple 32-bit bus.

A table of sixteen vector slots gives priority. Each slot has a control byte and a handler address. A slot's index is its priority, and slot 0 is the most urgent. When the handler reads the vector register, it gets the address for the most urgent pending slot, and the block raises its active priority to that slot. Less urgent sources then stay off the normal output until the handler writes the vector register. That write drops the active level back to the level saved at entry, so nested service unwinds like a stack. A separate default address is returned when no slot matches.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A source is raw-pending when its `irq_in` bit or its software request bit (word 5, read/write) is 1. Word 2 reads the raw-pending vector, word 4 is the read/write enable register, and word 0 reads the raw & enable & ~route & unmasked vector.
- R2: A source whose enable bit is 0 affects neither `irq_o` nor `fiq_o`, whatever its input or request bit.
- R3: The routing register (word 3) sends each enabled pending source to `fiq_o` when its bit is 1, and to `irq_o` when its bit is 0. `fiq_o` does not depend on the active priority level.
- R4: Slot n keeps its handler address at word 0x40+n and its control byte at word 0x80+n. In the control byte, bit 5 marks the slot valid and bits 4:0 name its source. A slot whose bit 5 is 0 never matches.
- R5: A read of word 12 looks for the lowest-numbered valid slot that is below the active level and whose source is raw-pending. If one is found, the read returns that slot's address, saves the old level and makes the slot's index the active level.
- R6: If the word 12 read finds no matching slot, it returns the default address and leaves the active level unchanged.
- R7: At active level L below 16, `irq_o` is driven only by sources named in valid slots numbered below L. At the idle level 16, every enabled source routed to the normal output drives `irq_o`.
- R8: A write of any value to word 12 restores the level that was saved when the active level was entered. A write at the idle level leaves it idle.
- R9: The default handler address is read/write at word 13.
- R10: A write to the test word 0xC0 has no effect, and that word reads 0. Reads of unassigned words return 0, and writes to them change nothing.
- R11: After reset, all enable, routing, request, slot control and address registers are 0, the level is idle (16), and both outputs are low.
- R12: Read data appears on `bus_rdata` at the clock edge that accepts the read, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level interrupt inputs |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
On every cycle the assertions check that disabled sources stay quiet, that the fast output needs a routing bit, and that the idle level masks nothing. They also check that a vector read can only raise urgency, that a vector write can only lower it, and that the level holds steady otherwise. Only the bench's scenarios can show which handler address a read returns, the nested unwind through several saved levels, and the rule that the scan stops at the active level. The same goes for the default-address fallback and for the no-effect cases at the test word and at unassigned words.

// File: rtl/vic_pkg.sv
package vic_pkg;
   // Word indices inside the register window
   localparam int VIC_W_IRQ_STAT  = 0;
   localparam int VIC_W_FIQ_STAT  = 1;
   localparam int VIC_W_RAW       = 2;
   localparam int VIC_W_ROUTE     = 3;
   localparam int VIC_W_ENABLE    = 4;
   localparam int VIC_W_SOFT      = 5;
   localparam int VIC_W_VEC       = 12;
   localparam int VIC_W_DEFVEC    = 13;
   localparam int VIC_W_SLOT_ADDR = 'h40;
   localparam int VIC_W_SLOT_CTRL = 'h80;
endpackage

// File: rtl/vic_prio_mask.sv
module vic_prio_mask #(
   parameter int N_SRC   = 32,
   parameter int N_SLOT  = 16,
   parameter int SRC_W   = 5,
   parameter int SLOT_IW = 4,
   parameter int PW      = 5
) (
   input  logic [N_SLOT-1:0]            slot_on,
   input  logic [N_SLOT-1:0][SRC_W-1:0] slot_src,
   input  logic [N_SRC-1:0]             raw,
   input  logic [PW-1:0]                cur,
   output logic [N_SRC-1:0]             gate,
   output logic                         hit,
   output logic [SLOT_IW-1:0]           hit_slot
);
   // outrank[k] : sources of valid slots numbered below k
   logic [N_SLOT:0][N_SRC-1:0] outrank;
   logic [N_SLOT-1:0]          cand;

   assign outrank[0] = '0;

   for (genvar n = 0; n < N_SLOT; n++) begin : g_slot
      assign outrank[n+1] = outrank[n] |
                            (slot_on[n] ? (N_SRC'(1) << slot_src[n]) : '0);
      assign cand[n] = slot_on[n] && raw[slot_src[n]] && (PW'(n) < cur);
   end

   assign gate = (cur >= PW'(N_SLOT)) ? '1 : outrank[cur];

   always_comb begin
      hit      = 1'b0;
      hit_slot = '0;
      for (int n = N_SLOT - 1; n >= 0; n--) begin
         if (cand[n]) begin
            hit      = 1'b1;
            hit_slot = SLOT_IW'(n);
         end
      end
   end
endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack #(
   parameter int N_SLOT  = 16,
   parameter int SLOT_IW = 4,
   parameter int PW      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [SLOT_IW-1:0] push_lvl,
   input  logic               pop,
   output logic [PW-1:0]      cur
);
   localparam logic [PW-1:0] IDLE = PW'(N_SLOT);

   logic [PW-1:0] saved_q [N_SLOT+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= IDLE;
         for (int k = 0; k <= N_SLOT; k++) saved_q[k] <= IDLE;
      end else if (push) begin
         saved_q[push_lvl] <= cur;
         cur               <= PW'(push_lvl);
      end else if (pop) begin
         cur <= saved_q[cur];
      end
   end
endmodule

// File: rtl/vic_out_stage.sv
module vic_out_stage #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_d,
   input  logic fiq_d,
   output logic irq_o,
   output logic fiq_o
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
         end else begin
            irq_o <= irq_d;
            fiq_o <= fiq_d;
         end
      end
   end else begin : g_comb
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign irq_o = irq_d;
      assign fiq_o = fiq_d;
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int N_SRC   = 32,
   parameter int N_SLOT  = 16,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter int CTRL_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              fiq_o
);
   localparam int SRC_W   = $clog2(N_SRC);
   localparam int SLOT_IW = $clog2(N_SLOT);
   localparam int PW      = $clog2(N_SLOT + 1);
   localparam int WI_W    = ADDR_W - 2;

   if (N_SRC != (1 << SRC_W)) begin : g_chk_src
      $error("N_SRC must be a power of two");
   end
   if (N_SRC > DATA_W) begin : g_chk_dw
      $error("N_SRC must fit the data width");
   end
   if (N_SLOT < 2 || N_SLOT > 64) begin : g_chk_slot
      $error("N_SLOT must lie in 2..64");
   end
   if (CTRL_W < SRC_W + 1) begin : g_chk_ctrl
      $error("CTRL_W too narrow for source field and valid bit");
   end

   logic [N_SRC-1:0]  en_q, sel_q, soft_q;
   logic [CTRL_W-1:0] ctrl_q  [N_SLOT];
   logic [DATA_W-1:0] vaddr_q [N_SLOT];
   logic [DATA_W-1:0] defv_q;
   logic [DATA_W-1:0] rd_val;

   logic [WI_W-1:0] widx;
   logic            wr_acc, rd_acc, vec_hit_addr;
   logic [1:0]      unused_lsb;

   assign widx         = bus_addr[ADDR_W-1:2];
   assign unused_lsb   = bus_addr[1:0];
   assign wr_acc       = bus_sel && bus_wr;
   assign rd_acc       = bus_sel && !bus_wr;
   assign vec_hit_addr = (widx == WI_W'(VIC_W_VEC));

   // slot fields
   logic [N_SLOT-1:0]            slot_on;
   logic [N_SLOT-1:0][SRC_W-1:0] slot_src;
   for (genvar n = 0; n < N_SLOT; n++) begin : g_fields
      assign slot_on[n]  = ctrl_q[n][SRC_W];
      assign slot_src[n] = ctrl_q[n][SRC_W-1:0];
   end

   logic [N_SRC-1:0]   raw, gate;
   logic               hit;
   logic [SLOT_IW-1:0] hit_slot;
   logic [PW-1:0]      cur_lvl;

   assign raw = irq_in | soft_q;

   vic_prio_mask #(
      .N_SRC(N_SRC), .N_SLOT(N_SLOT), .SRC_W(SRC_W),
      .SLOT_IW(SLOT_IW), .PW(PW)
   ) u_mask (
      .slot_on(slot_on), .slot_src(slot_src), .raw(raw), .cur(cur_lvl),
      .gate(gate), .hit(hit), .hit_slot(hit_slot)
   );

   vic_prio_stack #(
      .N_SLOT(N_SLOT), .SLOT_IW(SLOT_IW), .PW(PW)
   ) u_stack (
      .clk(clk), .rst_n(rst_n),
      .push(rd_acc && vec_hit_addr && hit), .push_lvl(hit_slot),
      .pop(wr_acc && vec_hit_addr), .cur(cur_lvl)
   );

   logic [N_SRC-1:0] irq_vec, fiq_vec;
   assign irq_vec = raw & en_q & ~sel_q & gate;
   assign fiq_vec = raw & en_q & sel_q;

   vic_out_stage #(.OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n),
      .irq_d(|irq_vec), .fiq_d(|fiq_vec),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         sel_q  <= '0;
         soft_q <= '0;
         defv_q <= '0;
         for (int n = 0; n < N_SLOT; n++) begin
            ctrl_q[n]  <= '0;
            vaddr_q[n] <= '0;
         end
      end else if (wr_acc) begin
         if (widx == WI_W'(VIC_W_ENABLE)) en_q   <= bus_wdata[N_SRC-1:0];
         if (widx == WI_W'(VIC_W_ROUTE))  sel_q  <= bus_wdata[N_SRC-1:0];
         if (widx == WI_W'(VIC_W_SOFT))   soft_q <= bus_wdata[N_SRC-1:0];
         if (widx == WI_W'(VIC_W_DEFVEC)) defv_q <= bus_wdata;
         for (int n = 0; n < N_SLOT; n++) begin
            if (widx == WI_W'(VIC_W_SLOT_ADDR + n)) vaddr_q[n] <= bus_wdata;
            if (widx == WI_W'(VIC_W_SLOT_CTRL + n)) ctrl_q[n]  <= bus_wdata[CTRL_W-1:0];
         end
      end
   end

   // read mux
   always_comb begin
      rd_val = '0;
      case (widx)
         WI_W'(VIC_W_IRQ_STAT): rd_val = DATA_W'(irq_vec);
         WI_W'(VIC_W_FIQ_STAT): rd_val = DATA_W'(fiq_vec);
         WI_W'(VIC_W_RAW):      rd_val = DATA_W'(raw);
         WI_W'(VIC_W_ROUTE):    rd_val = DATA_W'(sel_q);
         WI_W'(VIC_W_ENABLE):   rd_val = DATA_W'(en_q);
         WI_W'(VIC_W_SOFT):     rd_val = DATA_W'(soft_q);
         WI_W'(VIC_W_VEC):      rd_val = hit ? vaddr_q[hit_slot] : defv_q;
         WI_W'(VIC_W_DEFVEC):   rd_val = defv_q;
         default: begin
            for (int n = 0; n < N_SLOT; n++) begin
               if (widx == WI_W'(VIC_W_SLOT_ADDR + n)) rd_val = vaddr_q[n];
               if (widx == WI_W'(VIC_W_SLOT_CTRL + n)) rd_val = DATA_W'(ctrl_q[n]);
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_acc) bus_rdata <= rd_val;
   end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
   parameter int N_SRC   = 32,
   parameter int N_SLOT  = 16,
   parameter int ADDR_W  = 12,
   parameter bit OUT_REG = 1'b0,
   parameter int PW      = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [N_SRC-1:0]  irq_in,
   input logic [N_SRC-1:0]  en_q,
   input logic [N_SRC-1:0]  sel_q,
   input logic [N_SRC-1:0]  soft_q,
   input logic [PW-1:0]     cur_lvl,
   input logic              irq_o,
   input logic              fiq_o
);
   localparam logic [PW-1:0] IDLE = PW'(N_SLOT);

   logic vec_rd, vec_wr;
   assign vec_rd = bus_sel && !bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(12));
   assign vec_wr = bus_sel &&  bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(12));

   if (!OUT_REG) begin : g_out
      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q == '0) |-> (!irq_o && !fiq_o)); // R2
      AST_FIQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_q == '0) |-> !fiq_o); // R3
      AST_IDLE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
         ((cur_lvl == IDLE) && (|((irq_in | soft_q) & en_q & ~sel_q))) |-> irq_o); // R7
   end

   AST_PUSH_NOT_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd |=> (cur_lvl <= $past(cur_lvl))); // R5
   AST_POP_NOT_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
      vec_wr |=> (cur_lvl >= $past(cur_lvl))); // R8
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(vec_rd || vec_wr) |=> $stable(cur_lvl)); // R5
   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_wr && (cur_lvl == IDLE) |=> (cur_lvl == IDLE)); // R8
endmodule

bind vec_irq_ctrl vic_checker #(
   .N_SRC(N_SRC), .N_SLOT(N_SLOT), .ADDR_W(ADDR_W),
   .OUT_REG(OUT_REG), .PW(PW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .irq_in(irq_in), .en_q(en_q), .sel_q(sel_q),
   .soft_q(soft_q), .cur_lvl(cur_lvl), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
   localparam int NS = 32;
   localparam int NV = 16;

   localparam logic [11:0] A_RAW = 12'h008, A_ROUTE = 12'h00C, A_EN = 12'h010,
                           A_SOFT = 12'h014, A_VEC = 12'h030, A_DEF = 12'h034,
                           A_TEST = 12'h300, A_UNDEF = 12'hFC0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;

   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   vec_irq_ctrl u_vec_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   function automatic int src_of(int n); return (n * 7 + 3) % NS; endfunction
   function automatic logic [31:0] va_of(int n); return 32'h1000 + n * 16; endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      @(negedge clk);
      chk("R11 irq", 32'(irq_o), 0);
      chk("R11 fiq", 32'(fiq_o), 0);
      rd(A_EN, d);   chk("R11 enable", d, 0);
      rd(A_SOFT, d); chk("R11 soft", d, 0);
      rd(12'h100, d); chk("R11 slot addr", d, 0);
      rd(12'h200, d); chk("R11 slot ctrl", d, 0);
      rd(A_VEC, d);  chk("R6 vec at reset", d, 0);

      // R9 / R12 default address
      wr(A_DEF, 32'hDEF0_0000);
      rd(A_DEF, d); chk("R9 R12 default readback", d, 32'hDEF0_0000);

      wr(A_EN, 32'hFFFF_FFFF);
      rd(A_EN, d); chk("R1 enable readback", d, 32'hFFFF_FFFF);

      // R1 / R3 sweep every source
      for (int s = 0; s < NS; s++) begin
         irq_in = 32'(1) << s;
         @(negedge clk);
         chk("R1 hw irq", 32'(irq_o), 1);
         chk("R3 hw no fiq", 32'(fiq_o), 0);
         rd(A_RAW, d); chk("R1 raw", d, 32'(1) << s);
         wr(A_ROUTE, 32'(1) << s);
         chk("R3 fiq routed", 32'(fiq_o), 1);
         chk("R3 irq off when routed", 32'(irq_o), 0);
         wr(A_ROUTE, 0);
         irq_in = '0;
         wr(A_SOFT, 32'(1) << s);
         chk("R1 soft irq", 32'(irq_o), 1);
         wr(A_SOFT, 0);
         chk("R1 cleared", 32'(irq_o), 0);
      end

      // R2 enable gating, per source
      for (int s = 0; s < NS; s++) begin
         wr(A_EN, 32'(1) << s);
         irq_in = ~(32'(1) << s);
         @(negedge clk);
         chk("R2 others disabled", 32'(irq_o), 0);
         irq_in = '1;
         @(negedge clk);
         chk("R2 own enabled", 32'(irq_o), 1);
      end
      wr(A_EN, 0);
      wr(A_ROUTE, 32'hFFFF_FFFF);
      chk("R2 no fiq when disabled", 32'(fiq_o), 0);
      chk("R2 no irq when disabled", 32'(irq_o), 0);
      wr(A_ROUTE, 0);
      irq_in = '0;
      wr(A_EN, 32'hFFFF_FFFF);

      // R4 program slots
      for (int n = 0; n < NV; n++) begin
         wr(12'h200 + 12'(n * 4), 32'h20 | 32'(src_of(n)));
         wr(12'h100 + 12'(n * 4), va_of(n));
         rd(12'h200 + 12'(n * 4), d); chk("R4 ctrl readback", d, 32'h20 | 32'(src_of(n)));
         rd(12'h100 + 12'(n * 4), d); chk("R4 addr readback", d, va_of(n));
      end

      // R5 / R7 / R8 single-slot sweep
      for (int n = 0; n < NV; n++) begin
         wr(A_SOFT, 32'(1) << src_of(n));
         rd(A_VEC, d); chk("R5 vector", d, va_of(n));
         chk("R7 masked at own level", 32'(irq_o), 0);
         wr(A_VEC, 0);
         chk("R8 unmasked after pop", 32'(irq_o), 1);
         wr(A_SOFT, 0);
      end

      // nesting
      wr(A_SOFT, (32'(1) << src_of(5)) | (32'(1) << src_of(9)));
      rd(A_VEC, d); chk("R5 nest first", d, va_of(5));
      chk("R7 level 5 masks 5 and 9", 32'(irq_o), 0);
      rd(A_VEC, d); chk("R6 scan stops at level", d, 32'hDEF0_0000);
      chk("R6 level unchanged", 32'(irq_o), 0);
      wr(A_SOFT, (32'(1) << src_of(5)) | (32'(1) << src_of(9)) | (32'(1) << src_of(2)));
      chk("R7 more urgent passes", 32'(irq_o), 1);
      rd(A_VEC, d); chk("R5 nest second", d, va_of(2));
      chk("R7 level 2", 32'(irq_o), 0);
      wr(A_SOFT, (32'(1) << src_of(5)) | (32'(1) << src_of(9)));
      chk("R7 level 2 after clear", 32'(irq_o), 0);
      wr(A_VEC, 0);
      chk("R8 back to level 5", 32'(irq_o), 0);
      wr(A_VEC, 0);
      chk("R8 back to idle", 32'(irq_o), 1);
      rd(A_VEC, d); chk("R8 idle rescans", d, va_of(5));
      wr(A_VEC, 0);
      wr(A_SOFT, 0);

      // R6 non-vectored source at idle
      irq_in = 32'h1;
      @(negedge clk);
      rd(A_VEC, d); chk("R6 default", d, 32'hDEF0_0000);
      chk("R6 idle kept", 32'(irq_o), 1);

      // R8 pop at idle
      wr(A_VEC, 32'h5A5A);
      chk("R8 idle pop stays idle", 32'(irq_o), 1);
      irq_in = '0;

      // R4 invalid slot
      wr(12'h200 + 12'(3 * 4), 32'(src_of(3)));
      wr(A_SOFT, 32'(1) << src_of(3));
      rd(A_VEC, d); chk("R4 invalid slot ignored", d, 32'hDEF0_0000);
      chk("R4 invalid slot irq", 32'(irq_o), 1);
      wr(A_SOFT, 0);

      // R10 test word and unassigned words
      wr(A_TEST, 32'hFFFF_FFFF);
      rd(A_TEST, d); chk("R10 test reads 0", d, 0);
      chk("R10 test no irq", 32'(irq_o), 0);
      wr(A_UNDEF, 32'h0);
      wr(12'h020, 32'h0);
      rd(A_EN, d); chk("R10 enable untouched", d, 32'hFFFF_FFFF);
      rd(A_UNDEF, d); chk("R10 undefined reads 0", d, 0);
      rd(A_DEF, d); chk("R10 default untouched", d, 32'hDEF0_0000);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule